// File: doc/BRIEF.md
# PCM Frame Serial Port

This block sits between a voice codec core and a synchronous serial PCM link. Once per frame it takes one parallel transmit sample from the core and shifts it out on a serial data line. It also shifts one receive sample in from the serial line and hands it to the core. The link is timed by an external bit clock and frame sync. Both are sampled in the block's own faster system clock, so the same logic serves any bit rate whose phases are long enough to be seen.

Two sync conventions are supported. In long-frame mode the first data bit shares its bit slot with the rising edge of sync. In short-frame mode sync is a one-slot pulse and the first data bit follows in the next slot. The word is either an 8-bit companded code or a 14-bit two's-complement linear sample, selected at run time. Each direction can be muted on its own. Outside its word slot the transmit line is released: its output enable is low.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, `pcm_oe`, `pcm_out`, `tx_take` and `rx_valid` are 0 and `rx_word` is all zeros.
- R2: With `short_frame`=0, a frame starts at the bit-clock rising edge where `fsync` is seen high after being low at the previous rising edge. The first (most significant) transmit bit is driven from that edge onward.
- R3: With `short_frame`=1, a frame starts at the rising edge after one where `fsync` was seen high, provided `fsync` is now low. The first transmit bit is driven from that edge onward.
- R4: With `lin_mode`=0 the word is 8 bits and `tx_word[7:0]` is sent, bit 7 first. With `lin_mode`=1 it is 14 bits and `tx_word[13:0]` is sent, bit 13 first. `lin_mode` is taken at frame start, so a change in mid-word has no effect until the next frame.
- R5: `pcm_out` and `pcm_oe` change only right after a bit-clock rising edge. `pcm_oe` is high for exactly one word of bit slots and falls at the rising edge after the last bit.
- R6: Receive bits are sampled on bit-clock falling edges, most significant bit first, starting with the falling edge in the first bit slot. After the last bit, `rx_valid` pulses for one cycle with the word on `rx_word`. An 8-bit word sits in `rx_word[7:0]` with bits 13..8 zero. `rx_word` holds its value between pulses.
- R7: `tx_take` pulses for one cycle at every frame start, and `tx_word` is captured in that cycle.
- R8: With `tx_mute`=1 at frame start, every bit of that word is sent as 0 while `pcm_oe` stays high. With `rx_mute`=1 at frame start, that word is delivered as all zeros.
- R9: A new frame start in the middle of a word abandons it. Transmission restarts with a freshly captured word, and the partly received word produces no `rx_valid`.
- R10: The port works for any bit-clock rate whose high and low phases each last at least 2 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External PCM bit clock |
| fsync | input | 1 | External frame sync |
| pcm_in | input | 1 | Serial receive data |
| short_frame | input | 1 | 0 long-frame sync, 1 short-frame sync |
| lin_mode | input | 1 | 0 8-bit companded word, 1 14-bit linear word |
| tx_mute | input | 1 | Send zeros in place of the transmit sample |
| rx_mute | input | 1 | Deliver zeros in place of the received sample |
| tx_word | input | 14 | Transmit sample from the core |
| tx_take | output | 1 | One-cycle strobe: transmit sample captured |
| pcm_out | output | 1 | Serial transmit data |
| pcm_oe | output | 1 | Transmit line drive enable (low means high impedance) |
| rx_word | output | 14 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe: `rx_word` updated |

## Verification
On every cycle the assertions check these properties:
- the serial output moves only after a bit-clock rising edge;
- the capture and completion strobes last a single cycle;
- the received word changes only together with its strobe, and only after a falling edge;
- a companded word never has upper bits set;
- the bit counter stays in range.

Frame alignment in both sync formats, bit order, word length, muting, the mode change in mid-word and the abort on an early sync depend on whole stimulus sequences. Only the bench scenarios can show these. The bench sweeps both formats and both word sizes over several data patterns and three bit-clock rates.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    localparam int unsigned PCM_LIN_BITS = 14;
    localparam int unsigned PCM_CMP_BITS = 8;

    typedef enum logic {
        FMT_LONG  = 1'b0,
        FMT_SHORT = 1'b1
    } frame_fmt_e;
endpackage

// File: rtl/pcm_bclk_sense.sv
module pcm_bclk_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic pcm_in,
    output logic bit_rise,
    output logic bit_fall,
    output logic sync_lvl,
    output logic din_lvl
);
    typedef struct packed {
        logic bclk_a;
        logic bclk_b;
        logic sync_a;
        logic din_a;
    } sense_t;

    sense_t sn_d, sn_q;

    always_comb begin
        sn_d        = sn_q;
        sn_d.bclk_a = bclk;
        sn_d.bclk_b = sn_q.bclk_a;
        sn_d.sync_a = fsync;
        sn_d.din_a  = pcm_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sn_q <= '0;
        else        sn_q <= sn_d;
    end

    assign bit_rise = sn_q.bclk_a & ~sn_q.bclk_b;
    assign bit_fall = ~sn_q.bclk_a & sn_q.bclk_b;
    assign sync_lvl = sn_q.sync_a;
    assign din_lvl  = sn_q.din_a;
endmodule

// File: rtl/pcm_frame_align.sv
module pcm_frame_align
    import pcm_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_rise,
    input  logic sync_lvl,
    input  logic short_sel,
    output logic frame_start
);
    typedef struct packed {
        logic sync_prev;
    } align_t;

    align_t al_d, al_q;
    frame_fmt_e fmt;

    assign fmt = frame_fmt_e'(short_sel);

    always_comb begin
        al_d = al_q;
        if (bit_rise) al_d.sync_prev = sync_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    always_comb begin
        if (fmt == FMT_SHORT) frame_start = bit_rise & al_q.sync_prev & ~sync_lvl;
        else                  frame_start = bit_rise & sync_lvl & ~al_q.sync_prev;
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
    parameter int LIN_BITS = 14,
    parameter int CMP_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                frame_start,
    input  logic                lin_mode,
    input  logic                tx_mute,
    input  logic [LIN_BITS-1:0] tx_word,
    output logic                tx_take,
    output logic                pcm_out,
    output logic                pcm_oe
);
    localparam int CW = $clog2(LIN_BITS + 1);
    localparam logic [CW-1:0] LIN_LAST = CW'(LIN_BITS - 1);
    localparam logic [CW-1:0] CMP_LAST = CW'(CMP_BITS - 1);

    typedef struct packed {
        logic [LIN_BITS-1:0] shreg;
        logic [CW-1:0]       left;
        logic                oe;
        logic                take;
    } tx_state_t;

    tx_state_t tx_d, tx_q;
    logic [LIN_BITS-1:0] aligned;

    always_comb begin
        if (lin_mode) aligned = tx_word;
        else          aligned = {tx_word[CMP_BITS-1:0], {(LIN_BITS-CMP_BITS){1'b0}}};
    end

    always_comb begin
        tx_d      = tx_q;
        tx_d.take = 1'b0;
        if (frame_start) begin
            tx_d.shreg = tx_mute ? '0 : aligned;
            tx_d.left  = lin_mode ? LIN_LAST : CMP_LAST;
            tx_d.oe    = 1'b1;
            tx_d.take  = 1'b1;
        end else if (bit_rise && tx_q.oe) begin
            if (tx_q.left == '0) begin
                tx_d.oe = 1'b0;
            end else begin
                tx_d.shreg = {tx_q.shreg[LIN_BITS-2:0], 1'b0};
                tx_d.left  = tx_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_take = tx_q.take;
    assign pcm_oe  = tx_q.oe;
    assign pcm_out = tx_q.oe & tx_q.shreg[LIN_BITS-1];

    a_r5_changes_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> ($stable(pcm_out) && $stable(pcm_oe)));
    a_r7_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.left <= LIN_LAST);
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
    parameter int LIN_BITS = 14,
    parameter int CMP_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_fall,
    input  logic                frame_start,
    input  logic                din_lvl,
    input  logic                lin_mode,
    input  logic                rx_mute,
    output logic [LIN_BITS-1:0] rx_word,
    output logic                rx_valid
);
    localparam int CW = $clog2(LIN_BITS + 1);
    localparam logic [CW-1:0] LIN_LEN = CW'(LIN_BITS);
    localparam logic [CW-1:0] CMP_LEN = CW'(CMP_BITS);

    typedef struct packed {
        logic [LIN_BITS-1:0] sh;
        logic [CW-1:0]       left;
        logic                act;
        logic                len14;
        logic                mute_l;
        logic [LIN_BITS-1:0] word;
        logic                valid;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (frame_start) begin
            rx_d.act    = 1'b1;
            rx_d.left   = lin_mode ? LIN_LEN : CMP_LEN;
            rx_d.len14  = lin_mode;
            rx_d.mute_l = rx_mute;
            rx_d.sh     = '0;
        end else if (bit_fall && rx_q.act) begin
            rx_d.sh   = {rx_q.sh[LIN_BITS-2:0], din_lvl};
            rx_d.left = rx_q.left - 1'b1;
            if (rx_q.left == CW'(1)) begin
                rx_d.act   = 1'b0;
                rx_d.valid = 1'b1;
                if (rx_q.mute_l)     rx_d.word = '0;
                else if (rx_q.len14) rx_d.word = rx_d.sh;
                else                 rx_d.word = {{(LIN_BITS-CMP_BITS){1'b0}}, rx_d.sh[CMP_BITS-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_word  = rx_q.word;
    assign rx_valid = rx_q.valid;

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r6_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid);
    a_r6_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bit_fall));
    a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_q.len14) |-> (rx_word[LIN_BITS-1:CMP_BITS] == '0));
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int LIN_BITS = PCM_LIN_BITS,
    parameter int CMP_BITS = PCM_CMP_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                fsync,
    input  logic                pcm_in,
    input  logic                short_frame,
    input  logic                lin_mode,
    input  logic                tx_mute,
    input  logic                rx_mute,
    input  logic [LIN_BITS-1:0] tx_word,
    output logic                tx_take,
    output logic                pcm_out,
    output logic                pcm_oe,
    output logic [LIN_BITS-1:0] rx_word,
    output logic                rx_valid
);
    logic bit_rise, bit_fall, sync_lvl, din_lvl, frame_start;

    pcm_bclk_sense u_sense (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .pcm_in(pcm_in),
        .bit_rise(bit_rise), .bit_fall(bit_fall), .sync_lvl(sync_lvl), .din_lvl(din_lvl)
    );

    pcm_frame_align u_align (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .sync_lvl(sync_lvl),
        .short_sel(short_frame), .frame_start(frame_start)
    );

    pcm_tx_serializer #(.LIN_BITS(LIN_BITS), .CMP_BITS(CMP_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .frame_start(frame_start),
        .lin_mode(lin_mode), .tx_mute(tx_mute), .tx_word(tx_word),
        .tx_take(tx_take), .pcm_out(pcm_out), .pcm_oe(pcm_oe)
    );

    pcm_rx_deserializer #(.LIN_BITS(LIN_BITS), .CMP_BITS(CMP_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .frame_start(frame_start),
        .din_lvl(din_lvl), .lin_mode(lin_mode), .rx_mute(rx_mute),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );
endmodule

// File: tb/sim_pcm_frame_port.sv
module sim_pcm_frame_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        pcm_in = 1'b0;
    logic        short_frame = 1'b0;
    logic        lin_mode = 1'b0;
    logic        tx_mute = 1'b0;
    logic        rx_mute = 1'b0;
    logic [13:0] tx_word = '0;
    logic        tx_take, pcm_out, pcm_oe, rx_valid;
    logic [13:0] rx_word;

    int nchk = 0, nerr = 0, half = 2;
    int take_cnt = 0, valid_cnt = 0;
    logic [13:0] last_rx = '0;
    bit done = 0;

    always #2 clk = ~clk;

    pcm_frame_port u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .pcm_in(pcm_in),
        .short_frame(short_frame), .lin_mode(lin_mode), .tx_mute(tx_mute),
        .rx_mute(rx_mute), .tx_word(tx_word), .tx_take(tx_take),
        .pcm_out(pcm_out), .pcm_oe(pcm_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_take) take_cnt++;
            if (rx_valid) begin
                valid_cnt++;
                last_rx = rx_word;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit slot: rising edge with new sync/data, falling edge, then sample near slot end
    task automatic slot(input logic s, input logic d);
        bclk = 1'b1; fsync = s; pcm_in = d;
        repeat (half) @(negedge clk);
        bclk = 1'b0;
        repeat (half) @(negedge clk);
    endtask

    task automatic run_frame(input bit shortf, input bit lin, input logic [13:0] txw,
                             input logic [13:0] rxw, input bit tm, input bit rm, input int flip_at);
        int w;
        logic [13:0] exp_rx;
        string rq;
        w = lin ? 14 : 8;
        rq = shortf ? "R3/R4 tx bit" : "R2/R4 tx bit";
        if (tm) rq = "R8 tx mute bit";
        short_frame = shortf; lin_mode = lin; tx_mute = tm; rx_mute = rm; tx_word = txw;
        slot(1'b0, 1'b0);
        take_cnt = 0; valid_cnt = 0;
        if (shortf) slot(1'b1, 1'b0);
        for (int i = 0; i < w; i++) begin
            logic eb, db;
            db = lin ? rxw[13-i] : rxw[7-i];
            eb = tm ? 1'b0 : (lin ? txw[13-i] : txw[7-i]);
            if (i == flip_at) lin_mode = ~lin_mode;
            slot(shortf ? 1'b0 : (i < 3), db);
            chk(pcm_oe === 1'b1, "R5 oe in slot", {31'b0, pcm_oe}, 1);
            chk(pcm_out === eb, rq, {31'b0, pcm_out}, {31'b0, eb});
        end
        slot(1'b0, 1'b0);
        chk(pcm_oe === 1'b0, "R5 oe after word", {31'b0, pcm_oe}, 0);
        chk(take_cnt == 1, "R7 take count", take_cnt, 1);
        chk(valid_cnt == 1, "R6 valid count", valid_cnt, 1);
        exp_rx = rm ? 14'h0 : (lin ? rxw : {6'b0, rxw[7:0]});
        chk(last_rx === exp_rx, rm ? "R8 rx mute word" : "R6 rx word", {18'b0, last_rx}, {18'b0, exp_rx});
        lin_mode = lin;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [13:0] wa, wb, ra, rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pcm_oe === 1'b0, "R1 oe", {31'b0, pcm_oe}, 0);
        chk(pcm_out === 1'b0, "R1 out", {31'b0, pcm_out}, 0);
        chk(tx_take === 1'b0, "R1 take", {31'b0, tx_take}, 0);
        chk(rx_valid === 1'b0, "R1 valid", {31'b0, rx_valid}, 0);
        chk(rx_word === 14'h0, "R1 word", {18'b0, rx_word}, 0);

        // R10 sweep over bit-clock rates, both formats and sizes
        for (int hs = 0; hs < 3; hs++) begin
            half = (hs == 0) ? 2 : (hs == 1) ? 3 : 5;
            for (int f = 0; f < 2; f++)
                for (int l = 0; l < 2; l++)
                    for (int k = 0; k < 4; k++) begin
                        logic [13:0] tw, rw;
                        tw = (k == 0) ? 14'h3FFF : (k == 1) ? 14'h2AAA :
                             14'((k * 5437 + hs * 911 + f * 37 + l * 3) & 32'h3FFF);
                        rw = ~tw ^ 14'(k * 131);
                        run_frame(f[0], l[0], tw, rw, 1'b0, 1'b0, -1);
                    end
        end

        half = 3;
        // R8 muting
        run_frame(1'b0, 1'b1, 14'h1234, 14'h0F0F, 1'b1, 1'b0, -1);
        run_frame(1'b1, 1'b0, 14'h00A5, 14'h005A, 1'b0, 1'b1, -1);
        // R4 mode change mid-word has no effect on the current word
        run_frame(1'b0, 1'b0, 14'h00C3, 14'h003C, 1'b0, 1'b0, 2);
        run_frame(1'b1, 1'b1, 14'h2D17, 14'h12E8, 1'b0, 1'b0, 5);

        // R9 early sync aborts the word in flight
        wa = 14'h3A5C; wb = 14'h05B3; ra = 14'h1111; rb = 14'h2C6A;
        short_frame = 1'b0; lin_mode = 1'b1; tx_mute = 1'b0; rx_mute = 1'b0; tx_word = wa;
        slot(1'b0, 1'b0);
        take_cnt = 0; valid_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            slot((i < 3), ra[13-i]);
            tx_word = wb;
            chk(pcm_out === wa[13-i], "R9 first word bit", {31'b0, pcm_out}, {31'b0, wa[13-i]});
        end
        for (int j = 0; j < 14; j++) begin
            slot((j < 3), rb[13-j]);
            chk(pcm_oe === 1'b1, "R9 oe restarted", {31'b0, pcm_oe}, 1);
            chk(pcm_out === wb[13-j], "R9 restarted bit", {31'b0, pcm_out}, {31'b0, wb[13-j]});
        end
        slot(1'b0, 1'b0);
        chk(pcm_oe === 1'b0, "R9 oe end", {31'b0, pcm_oe}, 0);
        chk(take_cnt == 2, "R9 take count", take_cnt, 2);
        chk(valid_cnt == 1, "R9 valid count", valid_cnt, 1);
        chk(last_rx === rb, "R9 rx word", {18'b0, last_rx}, {18'b0, rb});

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule